// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer whose control and timeout registers are guarded by a timed two-word key sequence. Software first writes a fixed opening key and then a fixed closing key to the unlock register. The closing key must arrive within a short gap after the opening key. A correct pair opens a configuration window for a fixed number of clock cycles. Only while that window is open are writes to the control register and the timeout register accepted. The block never ignores a broken key sequence: it raises a one-cycle reset request instead.

While enabled, a down-counter runs from the timeout value. Software reloads it by writing a separate refresh key pair. If the counter reaches zero, the block raises a one-cycle reset request and reloads the counter. Clearing the enable bit inside the window freezes the countdown. A two-bit status output shows whether the block is waiting for the closing key and whether the configuration window is open, so that the window edges can be seen to the cycle.

Top module: `wdt_keyed_guard`

## Requirements
- R1: After reset the control register reads 0x0001 (counting enabled), the timeout register reads TIMEOUT (default 1000), the status view is 0 and the reset request is low.
- R2: Writing 0xC520 and then 0xD928 to address 0xE unlocks the block when the second write falls no more than KEY_GAP (20) clock edges after the first. A correct pair produces no reset request.
- R3: If the closing key has not arrived by the KEY_GAP-th edge after the opening key, the block raises the reset request for exactly one cycle after that edge and returns to the locked state.
- R4: A wrong value written to address 0xE (a bad opening key, or anything other than 0xD928 as the closing key, including a repeated 0xC520) raises the reset request for one cycle after that write and locks the block.
- R5: After unlock the window stays open for exactly CFG_WIN (256) edges. Writes to the control register (0x0) and the timeout register (0x4) take effect on those edges only.
- R6: A write to 0x0 or 0x4 while the block is locked or waiting, or after the window has closed, leaves the register unchanged.
- R7: Control bit 0 enables counting. While it is 0 the counter holds its value and no timeout reset is raised.
- R8: While enabled, the counter decrements on each edge. On an edge where it reads zero, the reset request goes high for one cycle and the counter reloads from the timeout register, so reset pulses repeat every timeout+1 cycles.
- R9: Writing 0x5A0F and then, on the next write to 0xC, 0xF0A5 reloads the counter from the timeout register. Any other value, or the closing refresh key without the opening one, has no effect on the counter.
- R10: Reads are registered: bus_rdata shows the selected register one cycle after bus_rd. The map is 0x0 control, 0x2 status (bit 0 window open, bit 1 waiting for closing key), 0x4 timeout, 0x6 current count, and 0 for other addresses. The stat_view output carries the same two status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Halfword register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, one cycle after bus_rd |
| wd_rst_req | output | 1 | One-cycle system reset request |
| stat_view | output | 2 | Bit 1 waiting for closing key, bit 0 configuration window open |

## Verification
The bench targets the exact edges of both timing windows. It sends a closing key on the 20th edge, where it must still be accepted, and lets the gap lapse by one edge, where it must give a reset. It writes on the 256th edge of the window, where the write must be taken, and on the 257th, where it must be dropped. An off-by-one counter in either window would flip one of these results. Wrong, repeated and out-of-order keys are checked for a one-cycle reset rather than silence. The spacing between timeout pulses is measured after a valid refresh, after a bare closing refresh key and after an interrupted refresh pair, which catches a counter that reloads at the wrong time or accepts a broken pair. Freezing the count by clearing the enable bit is confirmed by reading the count twice.

// File: rtl/wdt_kg_pkg.sv
`timescale 1ns/1ps
package wdt_kg_pkg;

   // Lock sequencer states
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_WAIT = 2'd1,
      LK_OPEN = 2'd2
   } lk_state_e;

   // Halfword register offsets
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_STAT  = 2;
   localparam int unsigned OFS_TOVAL = 4;
   localparam int unsigned OFS_CNT   = 6;
   localparam int unsigned OFS_REFR  = 12;
   localparam int unsigned OFS_UNLK  = 14;

   typedef struct packed {
      logic key_wait;
      logic win_open;
   } stat_t;

endpackage

// File: rtl/wdt_kg_unlock.sv
`timescale 1ns/1ps
module wdt_kg_unlock
   import wdt_kg_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter logic [DATA_W-1:0] KEY1 = 16'hC520,
   parameter logic [DATA_W-1:0] KEY2 = 16'hD928,
   parameter int unsigned KEY_GAP = 20,
   parameter int unsigned CFG_WIN = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_we,
   input  logic [DATA_W-1:0] key_val,
   output logic              win_open,
   output logic              key_wait,
   output logic              seq_err
);

   localparam int unsigned GAP_W = $clog2(KEY_GAP + 1);
   localparam int unsigned WIN_W = $clog2(CFG_WIN + 1);
   localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(KEY_GAP);
   localparam logic [WIN_W-1:0] WIN_LEN = WIN_W'(CFG_WIN);
   localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);
   localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);

   lk_state_e        state_q, state_d;
   logic [GAP_W-1:0] gap_q, gap_d;
   logic [WIN_W-1:0] win_q, win_d;

   always_comb begin
      state_d = state_q;
      gap_d   = gap_q;
      win_d   = win_q;
      seq_err = 1'b0;
      case (state_q)
         LK_WAIT: begin
            if (key_we) begin
               if (key_val == KEY2) begin
                  state_d = LK_OPEN;
                  win_d   = WIN_LEN;
               end else begin
                  seq_err = 1'b1;
                  state_d = LK_IDLE;
               end
            end else if (gap_q == GAP_LIM) begin
               seq_err = 1'b1;
               state_d = LK_IDLE;
            end else begin
               gap_d = gap_q + GAP_ONE;
            end
         end
         default: begin
            if (key_we) begin
               if (key_val == KEY1) begin
                  state_d = LK_WAIT;
                  gap_d   = GAP_ONE;
               end else begin
                  seq_err = 1'b1;
                  state_d = LK_IDLE;
               end
            end else if (state_q == LK_OPEN) begin
               if (win_q == WIN_ONE) begin
                  state_d = LK_IDLE;
               end else begin
                  win_d = win_q - WIN_ONE;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         gap_q   <= '0;
         win_q   <= '0;
      end else begin
         state_q <= state_d;
         gap_q   <= gap_d;
         win_q   <= win_d;
      end
   end

   assign win_open = (state_q == LK_OPEN);
   assign key_wait = (state_q == LK_WAIT);

endmodule

// File: rtl/wdt_kg_count.sv
`timescale 1ns/1ps
module wdt_kg_count #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned TIMEOUT = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             kick,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);

   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(TIMEOUT);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign expire = run_en && !kick && (cnt_q == '0);
   assign cnt    = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_INIT;
      end else if (run_en) begin
         if (kick || expire) begin
            cnt_q <= reload;
         end else begin
            cnt_q <= cnt_q - CNT_ONE;
         end
      end
   end

endmodule

// File: rtl/wdt_kg_refresh.sv
`timescale 1ns/1ps
module wdt_kg_refresh #(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] RKEY1 = 16'h5A0F,
   parameter logic [DATA_W-1:0] RKEY2 = 16'hF0A5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_we,
   input  logic [DATA_W-1:0] ref_val,
   output logic              kick
);

   logic armed_q;

   assign kick = ref_we && armed_q && (ref_val == RKEY2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (ref_we) begin
         armed_q <= (ref_val == RKEY1);
      end
   end

endmodule

// File: rtl/wdt_keyed_guard.sv
`timescale 1ns/1ps
module wdt_keyed_guard
   import wdt_kg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned TIMEOUT = 1000,
   parameter int unsigned KEY_GAP = 20,
   parameter int unsigned CFG_WIN = 256,
   parameter logic [DATA_W-1:0] KEY1  = 16'hC520,
   parameter logic [DATA_W-1:0] KEY2  = 16'hD928,
   parameter logic [DATA_W-1:0] RKEY1 = 16'h5A0F,
   parameter logic [DATA_W-1:0] RKEY2 = 16'hF0A5,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wd_rst_req,
   output logic [1:0]        stat_view
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_TOVAL = ADDR_W'(OFS_TOVAL);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
   localparam logic [ADDR_W-1:0] A_REFR  = ADDR_W'(OFS_REFR);
   localparam logic [ADDR_W-1:0] A_UNLK  = ADDR_W'(OFS_UNLK);
   localparam logic [DATA_W-1:0] CTRL_INIT  = DATA_W'(1);
   localparam logic [CNT_W-1:0]  TOVAL_INIT = CNT_W'(TIMEOUT);

   // Elaboration-time parameter checks
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must hold offset 14");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W too small");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must not exceed DATA_W");
   end
   if (KEY1 == KEY2) begin : g_bad_keys
      $error("unlock keys must differ");
   end
   if (RKEY1 == RKEY2) begin : g_bad_rkeys
      $error("refresh keys must differ");
   end
   if (KEY_GAP < 1 || CFG_WIN < 1) begin : g_bad_win
      $error("KEY_GAP and CFG_WIN must be positive");
   end
   if (TIMEOUT >= (64'd1 << CNT_W)) begin : g_bad_to
      $error("TIMEOUT does not fit CNT_W");
   end

   logic              hit_unlk, hit_refr, hit_ctrl, hit_toval;
   logic              win_open, key_wait, seq_err;
   logic              kick, expire;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  toval_q;
   logic              rst_req_q;
   logic [DATA_W-1:0] rd_mux;
   stat_t             stat;

   assign hit_unlk  = bus_wr && (bus_addr == A_UNLK);
   assign hit_refr  = bus_wr && (bus_addr == A_REFR);
   assign hit_ctrl  = bus_wr && (bus_addr == A_CTRL)  && win_open;
   assign hit_toval = bus_wr && (bus_addr == A_TOVAL) && win_open;

   wdt_kg_unlock #(
      .DATA_W (DATA_W),
      .KEY1   (KEY1),
      .KEY2   (KEY2),
      .KEY_GAP(KEY_GAP),
      .CFG_WIN(CFG_WIN)
   ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_we  (hit_unlk),
      .key_val (bus_wdata),
      .win_open(win_open),
      .key_wait(key_wait),
      .seq_err (seq_err)
   );

   wdt_kg_refresh #(
      .DATA_W(DATA_W),
      .RKEY1 (RKEY1),
      .RKEY2 (RKEY2)
   ) u_refr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_we (hit_refr),
      .ref_val(bus_wdata),
      .kick   (kick)
   );

   wdt_kg_count #(
      .CNT_W  (CNT_W),
      .TIMEOUT(TIMEOUT)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run_en(ctrl_q[0]),
      .kick  (kick),
      .reload(toval_q),
      .cnt   (cnt_q),
      .expire(expire)
   );

   // Protected registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_INIT;
         toval_q <= TOVAL_INIT;
      end else begin
         if (hit_ctrl) begin
            ctrl_q <= bus_wdata;
         end
         if (hit_toval) begin
            toval_q <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   // Reset request: one cycle per violation or expiry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= seq_err || expire;
      end
   end

   assign wd_rst_req   = rst_req_q;
   assign stat.key_wait = key_wait;
   assign stat.win_open = win_open;
   assign stat_view    = stat;

   always_comb begin
      rd_mux = '0;
      case (bus_addr)
         A_CTRL:  rd_mux = ctrl_q;
         A_STAT:  rd_mux = DATA_W'(stat);
         A_TOVAL: rd_mux = DATA_W'(toval_q);
         A_CNT:   rd_mux = DATA_W'(cnt_q);
         default: rd_mux = '0;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (bus_rd) begin
            rdata_q <= rd_mux;
         end
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end

endmodule

// File: rtl/wdt_kg_checker.sv
`timescale 1ns/1ps
module wdt_kg_checker #(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned CFG_WIN = 256,
   parameter logic [DATA_W-1:0] KEY2 = 16'hD928
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              wd_rst_req,
   input logic              win_open,
   input logic              kick,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [CNT_W-1:0]  cnt_q
);

   localparam int unsigned RUN_W = $clog2(CFG_WIN + 2);
   localparam logic [ADDR_W-1:0] A_UNLK = ADDR_W'(wdt_kg_pkg::OFS_UNLK);

   logic [RUN_W-1:0] open_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_run <= '0;
      end else if (win_open) begin
         open_run <= open_run + RUN_W'(1);
      end else begin
         open_run <= '0;
      end
   end

   // R5
   win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> (open_run < RUN_W'(CFG_WIN)));

   // R2
   win_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(bus_wr && bus_addr == A_UNLK && bus_wdata == KEY2));

   // R6
   ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_open |=> $stable(ctrl_q));

   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[0] |=> $stable(cnt_q));

   // R8
   expire_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && cnt_q == '0 && !kick) |=> wd_rst_req);

endmodule

bind wdt_keyed_guard wdt_kg_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .CFG_WIN(CFG_WIN),
   .KEY2   (KEY2)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .wd_rst_req(wd_rst_req),
   .win_open  (win_open),
   .kick      (kick),
   .ctrl_q    (ctrl_q),
   .cnt_q     (cnt_q)
);

// File: tb/wdt_keyed_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_guard_tb_top;

   localparam logic [15:0] K_OPEN  = 16'hC520;
   localparam logic [15:0] K_CLOSE = 16'hD928;
   localparam logic [15:0] R_OPEN  = 16'h5A0F;
   localparam logic [15:0] R_CLOSE = 16'hF0A5;
   localparam int GAP = 20;
   localparam int WIN = 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        wd_rst_req;
   logic [1:0]  stat_view;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wdt_keyed_guard dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .wd_rst_req(wd_rst_req),
      .stat_view (stat_view)
   );

   // Behavioural reference model: 0 locked, 1 waiting, 2 open
   int          m_st, m_gap, m_win;
   logic [15:0] m_ctrl, m_toval, m_cnt, m_rd;
   bit          m_arm, m_rst;

   always @(posedge clk) begin : model
      int          o_st;
      logic [15:0] o_ctrl, o_toval, o_cnt;
      bit          viol, kick, kw, rw;
      if (!rst_n) begin
         m_st = 0; m_gap = 0; m_win = 0;
         m_ctrl = 16'h0001; m_toval = 16'd1000; m_cnt = 16'd1000;
         m_rd = '0; m_arm = 0; m_rst = 0;
      end else begin
         o_st = m_st; o_ctrl = m_ctrl; o_toval = m_toval; o_cnt = m_cnt;
         viol = 0; kick = 0;
         kw = bus_wr && bus_addr == 4'hE;
         rw = bus_wr && bus_addr == 4'hC;
         if (o_st == 1) begin
            if (kw && bus_wdata == K_CLOSE) begin m_st = 2; m_win = WIN; end
            else if (kw) begin viol = 1; m_st = 0; end
            else if (m_gap == GAP) begin viol = 1; m_st = 0; end
            else m_gap = m_gap + 1;
         end else begin
            if (kw && bus_wdata == K_OPEN) begin m_st = 1; m_gap = 1; end
            else if (kw) begin viol = 1; m_st = 0; end
            else if (o_st == 2) begin
               if (m_win == 1) m_st = 0; else m_win = m_win - 1;
            end
         end
         if (o_st == 2 && bus_wr && bus_addr == 4'h0) m_ctrl = bus_wdata;
         if (o_st == 2 && bus_wr && bus_addr == 4'h4) m_toval = bus_wdata;
         if (rw) begin
            kick = m_arm && bus_wdata == R_CLOSE;
            m_arm = (bus_wdata == R_OPEN);
         end
         m_rst = viol;
         if (o_ctrl[0]) begin
            if (kick) m_cnt = o_toval;
            else if (o_cnt == 0) begin m_rst = 1; m_cnt = o_toval; end
            else m_cnt = o_cnt - 16'd1;
         end
         if (bus_rd) begin
            case (bus_addr)
               4'h0: m_rd = o_ctrl;
               4'h2: m_rd = {14'd0, o_st == 1, o_st == 2};
               4'h4: m_rd = o_toval;
               4'h6: m_rd = o_cnt;
               default: m_rd = '0;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 R3 R4 rst_req vs model", {15'd0, wd_rst_req}, {15'd0, m_rst});
         chk("R5 R10 stat_view vs model", {14'd0, stat_view},
             {14'd0, m_st == 1, m_st == 2});
         chk("R10 rdata vs model", bus_rdata, m_rd);
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_pulse(input int maxn, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!wd_rst_req && n < maxn);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin : main
      logic [15:0] d, c1, c2;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 stat_view", {14'd0, stat_view}, 16'h0);
      chk("R1 rst_req", {15'd0, wd_rst_req}, 16'h0);
      rd(4'h0, d); chk("R1 ctrl", d, 16'h0001);
      rd(4'h4, d); chk("R1 R10 timeout", d, 16'd1000);
      rd(4'h2, d); chk("R10 status locked", d, 16'h0000);
      rd(4'h8, d); chk("R10 unmapped", d, 16'h0000);

      // R6 locked writes ignored
      wr(4'h0, 16'h0000);
      rd(4'h0, d); chk("R6 locked ctrl", d, 16'h0001);
      wr(4'h4, 16'd5);
      rd(4'h4, d); chk("R6 locked timeout", d, 16'd1000);

      // R2 unlock, R5 timeout write
      wr(4'hE, K_OPEN);
      chk("R10 waiting bit", {14'd0, stat_view}, 16'h0002);
      wr(4'hE, K_CLOSE);
      chk("R2 open", {14'd0, stat_view}, 16'h0001);
      chk("R2 no reset", {15'd0, wd_rst_req}, 16'h0);
      rd(4'h2, d); chk("R10 status open", d, 16'h0001);
      wr(4'h4, 16'd40);
      rd(4'h4, d); chk("R5 timeout written", d, 16'd40);

      // R8 countdown and expiry
      wait_pulse(1500, n);
      chk("R8 first expiry", {15'd0, wd_rst_req}, 16'h1);
      @(negedge clk);
      chk("R8 pulse width", {15'd0, wd_rst_req}, 16'h0);
      wait_pulse(200, n);
      chk("R8 period", 16'(n), 16'd40);

      // R9 refresh pair reloads
      idle(9);
      wr(4'hC, R_OPEN);
      wr(4'hC, R_CLOSE);
      wait_pulse(200, n);
      chk("R9 refresh reload", 16'(n), 16'd41);
      wr(4'hC, R_CLOSE);
      wait_pulse(200, n);
      chk("R9 bare closing key", 16'(n), 16'd40);
      wr(4'hC, R_OPEN);
      wr(4'hC, 16'h1234);
      wr(4'hC, R_CLOSE);
      wait_pulse(200, n);
      chk("R9 broken pair", 16'(n), 16'd38);

      // R7 disable by read-modify-write inside the window
      wr(4'hE, K_OPEN);
      wr(4'hE, K_CLOSE);
      rd(4'h0, d); chk("R7 ctrl before", d, 16'h0001);
      wr(4'h0, d & ~16'h0001);
      rd(4'h0, d); chk("R7 ctrl cleared", d, 16'h0000);
      idle(100);
      rd(4'h6, c1);
      idle(50);
      rd(4'h6, c2);
      chk("R7 count frozen", c2, c1);

      // R2 closing key on the last allowed edge; R5 window edges
      idle(300);
      wr(4'hE, K_OPEN);
      idle(GAP - 1);
      wr(4'hE, K_CLOSE);
      chk("R2 late-edge key accepted", {15'd0, wd_rst_req}, 16'h0);
      chk("R2 late-edge open", {14'd0, stat_view}, 16'h0001);
      idle(WIN - 2);
      rd(4'h2, d); chk("R5 open near end", d, 16'h0001);
      wr(4'h0, 16'h0002);
      chk("R5 closed after window", {14'd0, stat_view}, 16'h0000);
      rd(4'h0, d); chk("R5 last-edge write taken", d, 16'h0002);
      wr(4'hE, K_OPEN);
      wr(4'hE, K_CLOSE);
      idle(WIN);
      wr(4'h0, 16'h0000);
      rd(4'h0, d); chk("R6 write after window", d, 16'h0002);

      // R3 closing key too late
      wr(4'hE, K_OPEN);
      idle(GAP - 1);
      chk("R3 still waiting", {14'd0, stat_view}, 16'h0002);
      idle(1);
      chk("R3 late reset", {15'd0, wd_rst_req}, 16'h1);
      chk("R3 relocked", {14'd0, stat_view}, 16'h0000);
      @(negedge clk);
      chk("R3 one cycle", {15'd0, wd_rst_req}, 16'h0);

      // R4 wrong keys
      wr(4'hE, 16'h1234);
      chk("R4 bad first key", {15'd0, wd_rst_req}, 16'h1);
      idle(2);
      wr(4'hE, K_CLOSE);
      chk("R4 closing key first", {15'd0, wd_rst_req}, 16'h1);
      idle(2);
      wr(4'hE, K_OPEN);
      wr(4'hE, K_OPEN);
      chk("R4 repeated opening key", {15'd0, wd_rst_req}, 16'h1);
      chk("R4 locked after error", {14'd0, stat_view}, 16'h0000);
      idle(2);
      wr(4'hE, K_OPEN);
      wr(4'hE, 16'hD929);
      chk("R4 bad closing key", {15'd0, wd_rst_req}, 16'h1);
      @(negedge clk);
      chk("R4 one cycle", {15'd0, wd_rst_req}, 16'h0);
      rd(4'h0, d); chk("R6 ctrl kept", d, 16'h0002);

      idle(4);
      finish_run();
   end

endmodule